// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which receive slots will take an incoming CAN frame. It holds sixteen message-buffer filters and an eight-entry receive-FIFO filter table. Each filter entry is paired with one acceptance mask. That mask is either a single shared mask or a private mask belonging to the entry. Two mode inputs steer this choice. One turns the FIFO table on. The other makes every entry use its own private mask.

A frame is offered with a one-cycle strobe that carries its 29-bit identifier, its IDE bit and its RTR bit. One clock later the block presents a registered vector with one bit per entry. With the vector come the position of the lowest set bit and a flag that is high when no entry accepted the frame. The controller that stores the frame uses this result to pick a destination.

Filters and masks are written through a simple write port. Filter entries may be rewritten at any time. Mask registers are locked unless the freeze input is high.

Top module: `can_acc_filter`

## Requirements
- R1: After reset all filter entries read as zero, and the shared mask and every private mask hold all ones. The outputs show valid low, an all-zero vector, first index 0 and the no-match flag high.
- R2: In every mask, a 1 bit requires the frame bit to equal the filter bit, and a 0 bit makes that position a don't-care.
- R3: With individual masking off, buffers 0 to 13 use the shared mask, while buffers 14 and 15 always use their own private masks.
- R4: With individual masking on, the shared mask has no effect, and every buffer and every FIFO entry uses its own private mask.
- R5: FIFO entries can only hit while FIFO enable is high. When enabled, entries 0 to 5 use the shared mask (with individual masking off), and entries 6 and 7 always use their own private masks. When FIFO enable is low, vector bits 7:0 are zero.
- R6: A buffer hits only when its IDE bit equals the frame's IDE bit, whatever the mask says. The frame's RTR bit never affects a buffer.
- R7: A FIFO entry compares IDE under mask bit 29 and RTR under mask bit 30, in addition to the identifier bits 28:0.
- R8: For a standard frame (IDE=0), only identifier bits 28:18 take part in the compare. For an extended frame, bits 28:0 take part.
- R9: A write is performed when cfg_we_i is high at a clock edge. The write data holds the ID in bits 28:0, IDE in bit 29 and RTR in bit 30. The target code selects the register: 0 = buffer filter, 1 = FIFO filter, 2 = shared mask, 3 = buffer private mask, 4 = FIFO private mask. Writes to codes 2 to 4 are ignored unless freeze_i is high. Writes to codes 0 and 1 are always performed. A FIFO index of 8 or more is ignored.
- R10: The result registers load on the clock edge where frm_valid_i is high. hit_valid_o is high for exactly that one following cycle. The vector, the index and the flag hold their values until the next strobe.
- R11: Vector bit j (j<8) is FIFO entry j, and bit 8+i is buffer i. hit_first_o is the lowest set bit, and hit_none_o is high exactly when the vector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Freeze mode; unlocks mask writes |
| fifo_en_i | input | 1 | Enables the FIFO filter table |
| indiv_mask_i | input | 1 | All entries use private masks |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_tgt_i | input | 3 | Write target code |
| cfg_idx_i | input | 4 | Entry index for the write |
| cfg_data_i | input | 31 | Write data {RTR, IDE, ID} |
| frm_valid_i | input | 1 | Frame offered this cycle |
| frm_id_i | input | 29 | Frame identifier |
| frm_ide_i | input | 1 | Frame extended-format bit |
| frm_rtr_i | input | 1 | Frame remote-request bit |
| hit_valid_o | output | 1 | Result presented this cycle |
| hit_vec_o | output | 24 | Per-entry accept vector |
| hit_first_o | output | 5 | Lowest accepting position |
| hit_none_o | output | 1 | No entry accepted |

## Verification
The hardest situation to reach is one where a result depends on which mask was chosen. This needs a frame that differs from a filter only in bits that the shared mask ignores but the private mask checks, or the reverse. Random frames almost never match a 29-bit filter. The stimulus therefore builds each frame from a randomly chosen programmed entry and flips a sparse random set of bits. Masks are drawn with mixed density, and writes are attempted with freeze both high and low. This makes selection-dependent hits and misses common. Directed frames add the fixed private entries, the standard-format bit scope, and the IDE and RTR rules.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

    localparam int ID_W    = 29;
    localparam int STD_W   = 11;
    localparam int FIFO_W  = ID_W + 2;
    localparam int MBF_W   = ID_W + 1;

    typedef enum logic [2:0] {
        TGT_MB_FILT   = 3'd0,
        TGT_FIFO_FILT = 3'd1,
        TGT_GMASK     = 3'd2,
        TGT_MB_MASK   = 3'd3,
        TGT_FIFO_MASK = 3'd4
    } cfg_tgt_e;

    typedef struct packed {
        logic            rtr;
        logic            ide;
        logic [ID_W-1:0] id;
    } fifo_word_t;

    typedef struct packed {
        logic            ide;
        logic [ID_W-1:0] id;
    } mb_filt_t;

    function automatic logic [ID_W-1:0] id_scope(input logic ide);
        return ide ? {ID_W{1'b1}} : {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};
    endfunction

    function automatic logic id_equal(input logic [ID_W-1:0] a,
                                      input logic [ID_W-1:0] b,
                                      input logic [ID_W-1:0] mk,
                                      input logic            ide);
        return ((a ^ b) & mk & id_scope(ide)) == '0;
    endfunction

    function automatic logic mb_accept(input logic [ID_W-1:0] id,
                                       input logic            ide,
                                       input mb_filt_t        f,
                                       input logic [ID_W-1:0] mk);
        return (f.ide == ide) && id_equal(id, f.id, mk, ide);
    endfunction

    function automatic logic fifo_accept(input logic [ID_W-1:0] id,
                                         input logic            ide,
                                         input logic            rtr,
                                         input fifo_word_t      f,
                                         input fifo_word_t      mk);
        return id_equal(id, f.id, mk.id, ide)
            && (!mk.ide || (f.ide == ide))
            && (!mk.rtr || (f.rtr == rtr));
    endfunction

endpackage

// File: rtl/can_acc_regs.sv
module can_acc_regs
    import can_acc_pkg::*;
#(
    parameter int NUM_MB   = 16,
    parameter int NUM_FIFO = 8,
    parameter int IDX_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        freeze_i,
    input  logic                        we_i,
    input  logic [2:0]                  tgt_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [FIFO_W-1:0]           data_i,
    output mb_filt_t   [NUM_MB-1:0]     mb_filt_o,
    output logic       [NUM_MB-1:0][ID_W-1:0] mb_mask_o,
    output fifo_word_t [NUM_FIFO-1:0]   fifo_filt_o,
    output fifo_word_t [NUM_FIFO-1:0]   fifo_mask_o,
    output fifo_word_t                  gmask_o
);

    cfg_tgt_e tgt;
    logic     unlocked;

    assign tgt      = cfg_tgt_e'(tgt_i);
    assign unlocked = freeze_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mb_filt_o   <= '0;
            fifo_filt_o <= '0;
            mb_mask_o   <= '1;
            fifo_mask_o <= '1;
            gmask_o     <= '1;
        end else if (we_i) begin
            case (tgt)
                TGT_MB_FILT: begin
                    for (int k = 0; k < NUM_MB; k++)
                        if (int'(idx_i) == k) mb_filt_o[k] <= mb_filt_t'(data_i[MBF_W-1:0]);
                end
                TGT_FIFO_FILT: begin
                    for (int k = 0; k < NUM_FIFO; k++)
                        if (int'(idx_i) == k) fifo_filt_o[k] <= fifo_word_t'(data_i);
                end
                TGT_GMASK: begin
                    if (unlocked) gmask_o <= fifo_word_t'(data_i);
                end
                TGT_MB_MASK: begin
                    for (int k = 0; k < NUM_MB; k++)
                        if (unlocked && int'(idx_i) == k) mb_mask_o[k] <= data_i[ID_W-1:0];
                end
                TGT_FIFO_MASK: begin
                    for (int k = 0; k < NUM_FIFO; k++)
                        if (unlocked && int'(idx_i) == k) fifo_mask_o[k] <= fifo_word_t'(data_i);
                end
                default: ;
            endcase
        end
    end

    // R9: masks never move while freeze is low
    assert_gmask_locked_R9: assert property (@(posedge clk) disable iff (rst)
        !freeze_i |=> $stable(gmask_o));
    assert_privmask_locked_R9: assert property (@(posedge clk) disable iff (rst)
        !freeze_i |=> ($stable(mb_mask_o) && $stable(fifo_mask_o)));
    // R1: masks come out of reset as all ones
    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gmask_o == '1 && mb_mask_o == '1 && fifo_mask_o == '1));

endmodule

// File: rtl/can_acc_match.sv
module can_acc_match
    import can_acc_pkg::*;
#(
    parameter int NUM_MB          = 16,
    parameter int NUM_FIFO        = 8,
    parameter int PRIV_MB_FIRST   = 14,
    parameter int PRIV_FIFO_FIRST = 6,
    localparam int NUM_HIT        = NUM_MB + NUM_FIFO
) (
    input  logic                        fifo_en_i,
    input  logic                        indiv_i,
    input  logic [ID_W-1:0]             id_i,
    input  logic                        ide_i,
    input  logic                        rtr_i,
    input  mb_filt_t   [NUM_MB-1:0]     mb_filt_i,
    input  logic       [NUM_MB-1:0][ID_W-1:0] mb_mask_i,
    input  fifo_word_t [NUM_FIFO-1:0]   fifo_filt_i,
    input  fifo_word_t [NUM_FIFO-1:0]   fifo_mask_i,
    input  fifo_word_t                  gmask_i,
    output logic [NUM_HIT-1:0]          hit_o
);

    for (genvar j = 0; j < NUM_FIFO; j++) begin : g_fifo
        localparam bit PRIV = (j >= PRIV_FIFO_FIRST);
        fifo_word_t mk;
        assign mk       = (PRIV || indiv_i) ? fifo_mask_i[j] : gmask_i;
        assign hit_o[j] = fifo_en_i && fifo_accept(id_i, ide_i, rtr_i, fifo_filt_i[j], mk);
    end

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        localparam bit PRIV = (i >= PRIV_MB_FIRST);
        logic [ID_W-1:0] mk;
        assign mk                = (PRIV || indiv_i) ? mb_mask_i[i] : gmask_i.id;
        assign hit_o[NUM_FIFO+i] = mb_accept(id_i, ide_i, mb_filt_i[i], mk);
    end

endmodule

// File: rtl/can_acc_prio.sv
module can_acc_prio #(
    parameter int NUM_HIT  = 24,
    localparam int FIRST_W = $clog2(NUM_HIT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe_i,
    input  logic [NUM_HIT-1:0] hit_i,
    output logic               valid_o,
    output logic [NUM_HIT-1:0] vec_o,
    output logic [FIRST_W-1:0] first_o,
    output logic               none_o
);

    logic [FIRST_W-1:0] first_d;

    always_comb begin
        first_d = '0;
        for (int k = NUM_HIT - 1; k >= 0; k--)
            if (hit_i[k]) first_d = k[FIRST_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            vec_o   <= '0;
            first_o <= '0;
            none_o  <= 1'b1;
        end else begin
            valid_o <= strobe_i;
            if (strobe_i) begin
                vec_o   <= hit_i;
                first_o <= first_d;
                none_o  <= (hit_i == '0);
            end
        end
    end

    // R11: reported index points at a set bit
    assert_first_is_set_R11: assert property (@(posedge clk) disable iff (rst)
        !none_o |-> vec_o[first_o]);
    // R11: no bit below the reported index is set
    assert_first_is_lowest_R11: assert property (@(posedge clk) disable iff (rst)
        ((vec_o & ((NUM_HIT'(1) << first_o) - NUM_HIT'(1))) == '0));
    assert_none_empty_R11: assert property (@(posedge clk) disable iff (rst)
        none_o |-> (vec_o == '0));
    // R10: results hold between strobes
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> ($stable(vec_o) && $stable(none_o) && !valid_o));

endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
    import can_acc_pkg::*;
#(
    parameter int NUM_MB          = 16,
    parameter int NUM_FIFO        = 8,
    parameter int PRIV_MB_FIRST   = 14,
    parameter int PRIV_FIFO_FIRST = 6,
    localparam int NUM_HIT        = NUM_MB + NUM_FIFO,
    localparam int IDX_W          = $clog2(NUM_MB),
    localparam int FIRST_W        = $clog2(NUM_HIT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               freeze_i,
    input  logic               fifo_en_i,
    input  logic               indiv_mask_i,
    input  logic               cfg_we_i,
    input  logic [2:0]         cfg_tgt_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [FIFO_W-1:0]  cfg_data_i,
    input  logic               frm_valid_i,
    input  logic [ID_W-1:0]    frm_id_i,
    input  logic               frm_ide_i,
    input  logic               frm_rtr_i,
    output logic               hit_valid_o,
    output logic [NUM_HIT-1:0] hit_vec_o,
    output logic [FIRST_W-1:0] hit_first_o,
    output logic               hit_none_o
);

    mb_filt_t   [NUM_MB-1:0]           mb_filt;
    logic       [NUM_MB-1:0][ID_W-1:0] mb_mask;
    fifo_word_t [NUM_FIFO-1:0]         fifo_filt;
    fifo_word_t [NUM_FIFO-1:0]         fifo_mask;
    fifo_word_t                        gmask;
    logic       [NUM_HIT-1:0]          hit_comb;

    can_acc_regs #(.NUM_MB(NUM_MB), .NUM_FIFO(NUM_FIFO), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .freeze_i(freeze_i), .we_i(cfg_we_i),
        .tgt_i(cfg_tgt_i), .idx_i(cfg_idx_i), .data_i(cfg_data_i),
        .mb_filt_o(mb_filt), .mb_mask_o(mb_mask), .fifo_filt_o(fifo_filt),
        .fifo_mask_o(fifo_mask), .gmask_o(gmask)
    );

    can_acc_match #(.NUM_MB(NUM_MB), .NUM_FIFO(NUM_FIFO),
                    .PRIV_MB_FIRST(PRIV_MB_FIRST), .PRIV_FIFO_FIRST(PRIV_FIFO_FIRST)) u_match (
        .fifo_en_i(fifo_en_i), .indiv_i(indiv_mask_i), .id_i(frm_id_i),
        .ide_i(frm_ide_i), .rtr_i(frm_rtr_i), .mb_filt_i(mb_filt),
        .mb_mask_i(mb_mask), .fifo_filt_i(fifo_filt), .fifo_mask_i(fifo_mask),
        .gmask_i(gmask), .hit_o(hit_comb)
    );

    can_acc_prio #(.NUM_HIT(NUM_HIT)) u_prio (
        .clk(clk), .rst(rst), .strobe_i(frm_valid_i), .hit_i(hit_comb),
        .valid_o(hit_valid_o), .vec_o(hit_vec_o), .first_o(hit_first_o),
        .none_o(hit_none_o)
    );

    // R5: a disabled FIFO table reports no FIFO hits
    assert_fifo_off_R5: assert property (@(posedge clk) disable iff (rst)
        (frm_valid_i && !fifo_en_i) |=> (hit_vec_o[NUM_FIFO-1:0] == '0));

endmodule

// File: tb/can_acc_filter_test.sv
`timescale 1ns/1ps
module can_acc_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        freeze = 1'b0, fifo_en = 1'b0, indiv = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  tgt = '0;
    logic [3:0]  idx = '0;
    logic [30:0] data = '0;
    logic        fv = 1'b0;
    logic [28:0] fid = '0;
    logic        fide = 1'b0, frtr = 1'b0;
    logic        hv;
    logic [23:0] hvec;
    logic [4:0]  hfirst;
    logic        hnone;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [29:0] m_mbf [16];
    logic [28:0] m_mbm [16];
    logic [30:0] m_ff  [8];
    logic [30:0] m_fm  [8];
    logic [30:0] m_g;

    always #2.5 clk = ~clk;

    can_acc_filter uut (
        .clk(clk), .rst(rst), .freeze_i(freeze), .fifo_en_i(fifo_en),
        .indiv_mask_i(indiv), .cfg_we_i(we), .cfg_tgt_i(tgt), .cfg_idx_i(idx),
        .cfg_data_i(data), .frm_valid_i(fv), .frm_id_i(fid), .frm_ide_i(fide),
        .frm_rtr_i(frtr), .hit_valid_o(hv), .hit_vec_o(hvec),
        .hit_first_o(hfirst), .hit_none_o(hnone)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [28:0] scope(logic ide);
        return ide ? 29'h1FFFFFFF : {11'h7FF, 18'h0};
    endfunction

    function automatic logic [23:0] model(logic [28:0] id, logic ide, logic rtr);
        logic [23:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            logic [28:0] mk = (indiv || i >= 14) ? m_mbm[i] : m_g[28:0];
            r[8+i] = (m_mbf[i][29] == ide) && (((id ^ m_mbf[i][28:0]) & mk & scope(ide)) == 0);
        end
        for (int j = 0; j < 8; j++) begin
            logic [30:0] mk = (indiv || j >= 6) ? m_fm[j] : m_g;
            r[j] = fifo_en && (((id ^ m_ff[j][28:0]) & mk[28:0] & scope(ide)) == 0)
                 && (!mk[29] || m_ff[j][29] == ide) && (!mk[30] || m_ff[j][30] == rtr);
        end
        return r;
    endfunction

    task automatic cfg(int t, int ix, logic [30:0] d);
        @(negedge clk);
        we = 1'b1; tgt = 3'(t); idx = 4'(ix); data = d;
        case (t)
            0: m_mbf[ix] = d[29:0];
            1: if (ix < 8) m_ff[ix] = d;
            2: if (freeze) m_g = d;
            3: if (freeze) m_mbm[ix] = d[28:0];
            4: if (freeze && ix < 8) m_fm[ix] = d;
            default: ;
        endcase
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic frame(string tag, logic [28:0] id, logic ide, logic rtr);
        logic [23:0] e;
        logic [4:0]  f = '0;
        e = model(id, ide, rtr);
        for (int k = 23; k >= 0; k--) if (e[k]) f = 5'(k);
        @(negedge clk);
        fv = 1'b1; fid = id; fide = ide; frtr = rtr;
        @(negedge clk);
        fv = 1'b0; fid = ~id;
        chk({tag, " R10 valid"}, 32'(hv), 32'd1);
        chk({tag, " vector"}, 32'(hvec), 32'(e));
        chk({tag, " R11 none"}, 32'(hnone), 32'(e == 0));
        chk({tag, " R11 first"}, 32'(hfirst), 32'(f));
        @(negedge clk);
        chk({tag, " R10 hold"}, {7'(hv), hvec}, {7'd0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [30:0] base;
        void'($urandom(32'd7531));
        for (int i = 0; i < 16; i++) begin m_mbf[i] = '0; m_mbm[i] = '1; end
        for (int j = 0; j < 8; j++) begin m_ff[j] = '0; m_fm[j] = '1; end
        m_g = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R1 valid", 32'(hv), 0);
        chk("R1 vector", 32'(hvec), 0);
        chk("R1 none", 32'(hnone), 1);
        chk("R1 first", 32'(hfirst), 0);
        frame("R1 reset masks", '0, 1'b0, 1'b0);
        chk("R1 exact vector", 32'(hvec), 32'hFFFF00);

        // R9: mask write outside freeze is dropped, filter write is not
        cfg(2, 0, '0);
        cfg(0, 3, {2'b00, 29'h1 << 18});
        frame("R9 locked", 29'h1 << 18, 1'b0, 1'b0);
        chk("R9 locked vector", 32'(hvec), 32'h000800);
        freeze = 1'b1;
        cfg(2, 0, '0);
        // R3: buffers 0..13 now accept anything standard, 14 and 15 stay exact
        frame("R3 global", 29'h155 << 18, 1'b0, 1'b1);
        chk("R3 vector", 32'(hvec), 32'h3FFF00);
        // R4: private masks take over everywhere
        indiv = 1'b1;
        frame("R4 indiv", 29'h155 << 18, 1'b0, 1'b0);
        chk("R4 vector", 32'(hvec), 32'h000000);
        indiv = 1'b0;
        // R6: IDE mismatch on buffer never hits
        cfg(0, 5, {2'b01, 29'h0ABCDE});
        frame("R6 ide", 29'h0ABCDE, 1'b0, 1'b0);
        chk("R6 buffer5", 32'(hvec[13]), 0);
        // R8: standard frame ignores low bits, extended does not
        cfg(3, 14, '1);
        cfg(0, 14, {2'b00, 29'h12345678 & 29'h1FFC0000});
        frame("R8 std", 29'h12345678, 1'b0, 1'b0);
        chk("R8 std hit", 32'(hvec[22]), 1);
        cfg(0, 14, {2'b01, 29'h12345678 & 29'h1FFC0000});
        frame("R8 ext", 29'h12345678, 1'b1, 1'b0);
        chk("R8 ext miss", 32'(hvec[22]), 0);
        // R7 / R5: FIFO entry 6 with RTR under its private mask
        fifo_en = 1'b1;
        cfg(1, 6, {1'b1, 1'b1, 29'h00FF00FF});
        frame("R7 rtr checked", 29'h00FF00FF, 1'b1, 1'b0);
        chk("R7 miss", 32'(hvec[6]), 0);
        cfg(4, 6, {1'b0, 1'b1, 29'h1FFFFFFF});
        frame("R7 rtr masked", 29'h00FF00FF, 1'b1, 1'b0);
        chk("R7 hit", 32'(hvec[6]), 1);
        cfg(1, 9, '1);
        frame("R5 fifo on", 29'h0, 1'b0, 1'b0);
        fifo_en = 1'b0;
        frame("R5 fifo off", 29'h0, 1'b0, 1'b0);
        chk("R5 low bits", 32'(hvec[7:0]), 0);

        // R2 and mixed modes: random programming and near-miss frames
        for (int it = 0; it < 400; it++) begin
            freeze  = ($urandom % 4) != 0;
            fifo_en = $urandom % 2;
            indiv   = ($urandom % 3) == 0;
            repeat ($urandom % 3) begin
                int t = $urandom % 5;
                logic [30:0] d = 31'($urandom);
                if (t >= 2) d = ($urandom % 2) ? 31'($urandom | $urandom) : 31'($urandom & $urandom);
                cfg(t, $urandom % 16, d);
            end
            begin
                int k = $urandom % 24;
                logic [28:0] flip = 29'($urandom & $urandom & $urandom & $urandom);
                logic xide = ($urandom % 8) == 0;
                base = (k < 8) ? m_ff[k] : {1'b0, m_mbf[k-8]};
                frame(indiv ? "R4 R2 random" : (fifo_en ? "R5 R2 random" : "R3 R2 random"),
                      base[28:0] ^ flip, base[29] ^ xide, 1'($urandom));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule